// File: doc/BRIEF.md
# Oversampling UART Receiver

This block recovers asynchronous serial characters from a single receive line. A one-cycle sampling tick, produced elsewhere at a fixed multiple of the bit rate, paces every decision. The receiver works at either sixteen or eight ticks per bit, picked by a select input. A falling line is accepted as a start bit only after half a bit time of continuous low samples. From there on, each data bit, the optional parity bit and one stop bit are each read once per bit period, close to the middle of the bit.

The frame format comes from static inputs: a character length of five to eight bits, a nine-bit override, a bit-order select and a parity mode. These settings are captured when a start bit is accepted, so they apply to the whole character. At the end of the stop bit the block publishes the assembled word together with a parity-error flag and a framing-error flag, and pulses a data-valid strobe for one clock. Only one stop bit is ever examined. A transmitter that sends two stop bits is therefore received correctly, and the receiver can lock onto a start bit that follows a single stop bit directly. The line input passes through a two-stage synchronizer before it is sampled.

Top module: `uart_os_rx`

## Requirements
- R1: With `os8_i`=0 a bit lasts 16 ticks, and with `os8_i`=1 it lasts 8 ticks. Characters sent at either rate are decoded correctly.
- R2: A start is confirmed only on the 8th consecutive low tick sample (16x) or the 4th (8x). A low pulse that ends earlier produces no strobe, and the receiver then accepts the next valid character.
- R3: `len_i` values 0,1,2,3 select 5,6,7,8 data bits, and `nine_i`=1 selects 9 data bits whatever `len_i` holds. Bits of `data_o` above the selected length read 0.
- R4: With `msbf_i`=0 the first data bit on the line lands in `data_o[0]`. With `msbf_i`=1 it lands in `data_o[n-1]`, where n is the selected length.
- R5: `par_i` codes: 0 no parity bit, 1 even, 2 odd, 3 parity bit must be 0, 4 parity bit must be 1, and 5 to 7 act as 0. A parity bit that breaks the selected rule sets `perr_o`. With no parity, `perr_o` is 0.
- R6: Exactly one stop bit is sampled. If that sample is low, `ferr_o` is set. A start bit that follows a single stop bit immediately is received.
- R7: `valid_o` is high for exactly one clock per character. `data_o`, `perr_o` and `ferr_o` change only on that clock and hold their values until the next strobe.
- R8: After reset, `valid_o`, `data_o`, `perr_o` and `ferr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock sampling tick at 16x or 8x the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| os8_i | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| len_i | input | 2 | Character length code, 0..3 giving 5..8 bits |
| nine_i | input | 1 | 1: nine data bits |
| msbf_i | input | 1 | 1: most significant bit first |
| par_i | input | 3 | Parity mode code |
| data_o | output | DATA_W | Last received character |
| valid_o | output | 1 | One-clock strobe for a new character |
| perr_o | output | 1 | Parity error of the last character |
| ferr_o | output | 1 | Framing error of the last character |

## Verification
The parity check and the stop-bit check are resolved for the same character and reported on the same strobe. Their results therefore coincide in a single clock. The bench provokes this by sending a character whose parity bit is inverted and whose stop bit is driven low. It then requires exactly one strobe carrying both flags set and the correct data word. A second pairing is exercised as well: one character's stop sample followed directly by the next character's start detection. Two characters are sent back to back with a single stop bit, and the bench requires two strobes with the right words.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;

    localparam logic [2:0] PM_NONE = 3'd0;
    localparam logic [2:0] PM_EVEN = 3'd1;
    localparam logic [2:0] PM_ODD  = 3'd2;
    localparam logic [2:0] PM_ZERO = 3'd3;
    localparam logic [2:0] PM_ONE  = 3'd4;

    function automatic logic par_used(input logic [2:0] mode);
        return (mode == PM_EVEN) || (mode == PM_ODD) ||
               (mode == PM_ZERO) || (mode == PM_ONE);
    endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_par_chk.sv
module rx_par_chk
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [2:0]        mode_i,
    input  logic              pbit_i,
    output logic              err_o
);
    logic odd_ones;
    assign odd_ones = ^word_i;

    always_comb begin
        unique case (mode_i)
            PM_EVEN: err_o = odd_ones ^ pbit_i;
            PM_ODD:  err_o = ~(odd_ones ^ pbit_i);
            PM_ZERO: err_o = pbit_i;
            PM_ONE:  err_o = ~pbit_i;
            default: err_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int OS_HI   = 16,
    parameter int OS_LO   = 8,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              os8_i,
    input  logic [1:0]        len_i,
    input  logic              nine_i,
    input  logic              msbf_i,
    input  logic [2:0]        par_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              perr_o,
    output logic              ferr_o
);
    localparam int CW = $clog2(OS_HI + 1);
    localparam int IW = $clog2(DATA_W + 1);

    typedef struct packed {
        rx_state_e          st;
        logic [CW-1:0]      cnt;
        logic [CW-1:0]      os;
        logic [IW-1:0]      idx;
        logic [IW-1:0]      nb;
        logic               msbf;
        logic [2:0]         pm;
        logic               pe;
        logic [DATA_W-1:0]  sh;
        logic [DATA_W-1:0]  data;
        logic               valid;
        logic               perr;
        logic               ferr;
    } rx_regs_t;

    rx_regs_t q, n;
    logic     rxd_s;
    logic     par_bad;
    logic [IW-1:0] pos;
    logic [CW-1:0] cnt_inc;

    rx_sync #(.STAGES(SYNC_ST)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (rxd_s)
    );

    rx_par_chk #(.DATA_W(DATA_W)) i_par (
        .word_i (q.sh),
        .mode_i (q.pm),
        .pbit_i (rxd_s),
        .err_o  (par_bad)
    );

    assign pos     = q.msbf ? (q.nb - IW'(1) - q.idx) : q.idx;
    assign cnt_inc = q.cnt + CW'(1);

    always_comb begin
        n       = q;
        n.valid = 1'b0;
        if (tick_i) begin
            unique case (q.st)
                RX_IDLE: begin
                    if (!rxd_s) begin
                        n.st   = RX_START;
                        n.cnt  = CW'(1);
                        n.os   = os8_i ? CW'(OS_LO) : CW'(OS_HI);
                        n.nb   = nine_i ? IW'(DATA_W) : (IW'(5) + IW'(len_i));
                        n.msbf = msbf_i;
                        n.pm   = par_i;
                        n.pe   = 1'b0;
                        n.sh   = '0;
                    end
                end
                RX_START: begin
                    if (rxd_s) begin
                        n.st = RX_IDLE;
                    end else if (cnt_inc == (q.os >> 1)) begin
                        n.st  = RX_DATA;
                        n.cnt = '0;
                        n.idx = '0;
                    end else begin
                        n.cnt = cnt_inc;
                    end
                end
                RX_DATA: begin
                    n.cnt = cnt_inc;
                    if (cnt_inc == q.os) begin
                        n.cnt     = '0;
                        n.sh[pos] = rxd_s;
                        n.idx     = q.idx + IW'(1);
                        if (q.idx == q.nb - IW'(1))
                            n.st = par_used(q.pm) ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    n.cnt = cnt_inc;
                    if (cnt_inc == q.os) begin
                        n.cnt = '0;
                        n.pe  = par_bad;
                        n.st  = RX_STOP;
                    end
                end
                RX_STOP: begin
                    n.cnt = cnt_inc;
                    if (cnt_inc == q.os) begin
                        n.cnt   = '0;
                        n.st    = RX_IDLE;
                        n.valid = 1'b1;
                        n.data  = q.sh;
                        n.perr  = q.pe;
                        n.ferr  = ~rxd_s;
                    end
                end
                default: n.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign perr_o  = q.perr;
    assign ferr_o  = q.ferr;

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data_o) && $stable(perr_o) && $stable(ferr_o)));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((data_o >> q.nb) == '0));

    // R5
    no_par_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !par_used(q.pm)) |-> !perr_o);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != RX_IDLE) |-> (q.cnt < q.os));
endmodule

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       rxd_i = 1'b1;
    logic       os8_i = 1'b0;
    logic [1:0] len_i = 2'd3;
    logic       nine_i = 1'b0;
    logic       msbf_i = 1'b0;
    logic [2:0] par_i = 3'd0;
    logic [8:0] data_o;
    logic       valid_o, perr_o, ferr_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    logic [8:0] cap_d [0:3];
    logic       cap_p [0:3];
    logic       cap_f [0:3];

    always #10 clk = ~clk;

    uart_os_rx i_uart_os_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rxd_i(rxd_i),
        .os8_i(os8_i), .len_i(len_i), .nine_i(nine_i), .msbf_i(msbf_i),
        .par_i(par_i), .data_o(data_o), .valid_o(valid_o),
        .perr_o(perr_o), .ferr_o(ferr_o)
    );

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % 4;
            tick_i = (c == 0);
        end
    end

    always @(negedge clk) begin
        if (valid_o) begin
            if (n_valid < 4) begin
                cap_d[n_valid] = data_o;
                cap_p[n_valid] = perr_o;
                cap_f[n_valid] = ferr_o;
            end
            n_valid++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line_ticks(input logic v, input int ticks);
        rxd_i = v;
        repeat (ticks * 4) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] w, input int nb, input bit msbf,
                        input logic [2:0] pm, input bit bad_par, input bit bad_stop,
                        input int idle_bits);
        int os;
        logic p;
        os = os8_i ? 8 : 16;
        line_ticks(1'b0, os);
        for (int i = 0; i < nb; i++)
            line_ticks(msbf ? w[nb-1-i] : w[i], os);
        p = 1'b0;
        for (int i = 0; i < nb; i++) p = p ^ w[i];
        if (pm == 3'd1 || pm == 3'd2 || pm == 3'd3 || pm == 3'd4) begin
            if (pm == 3'd2) p = ~p;
            if (pm == 3'd3) p = 1'b0;
            if (pm == 3'd4) p = 1'b1;
            line_ticks(p ^ bad_par, os);
        end
        if (bad_stop) begin
            line_ticks(1'b0, os / 2 + 2);
            line_ticks(1'b1, os / 2 - 2);
        end else begin
            line_ticks(1'b1, os);
        end
        line_ticks(1'b1, os * idle_bits);
    endtask

    task automatic setup(input bit os8, input logic [1:0] len, input bit nine,
                         input bit msbf, input logic [2:0] pm);
        os8_i = os8; len_i = len; nine_i = nine; msbf_i = msbf; par_i = pm;
        n_valid = 0;
    endtask

    task automatic frame_ok(input string req, input logic [8:0] w, input int nb,
                            input bit perr, input bit ferr);
        logic [8:0] m;
        m = w & ((9'd1 << nb) - 9'd1);
        chk(n_valid == 1, {req, " strobe count"}, 9'(n_valid), 9'd1);
        chk(data_o == m, {req, " data"}, data_o, m);
        chk(perr_o == perr, {req, " perr"}, 9'(perr_o), 9'(perr));
        chk(ferr_o == ferr, {req, " ferr"}, 9'(ferr_o), 9'(ferr));
    endtask

    task automatic t_reset;
        chk(valid_o == 0 && perr_o == 0 && ferr_o == 0, "R8 flags", {6'd0, valid_o, perr_o, ferr_o}, 9'd0);
        chk(data_o == 0, "R8 data", data_o, 9'd0);
    endtask

    task automatic t_ratio;
        setup(0, 2'd3, 0, 0, 3'd0); send(9'h0A5, 8, 0, 3'd0, 0, 0, 2); frame_ok("R1 16x", 9'h0A5, 8, 0, 0);
        setup(1, 2'd3, 0, 0, 3'd0); send(9'h03C, 8, 0, 3'd0, 0, 0, 2); frame_ok("R1 8x", 9'h03C, 8, 0, 0);
    endtask

    task automatic t_length;
        setup(0, 2'd0, 0, 0, 3'd0); send(9'h1FF, 5, 0, 3'd0, 0, 0, 2); frame_ok("R3 len5", 9'h1FF, 5, 0, 0);
        setup(1, 2'd1, 0, 0, 3'd0); send(9'h12D, 6, 0, 3'd0, 0, 0, 2); frame_ok("R3 len6", 9'h12D, 6, 0, 0);
        setup(0, 2'd2, 0, 0, 3'd0); send(9'h055, 7, 0, 3'd0, 0, 0, 2); frame_ok("R3 len7", 9'h055, 7, 0, 0);
        setup(1, 2'd0, 1, 0, 3'd0); send(9'h1A3, 9, 0, 3'd0, 0, 0, 2); frame_ok("R3 nine", 9'h1A3, 9, 0, 0);
    endtask

    task automatic t_order;
        setup(0, 2'd3, 0, 1, 3'd0); send(9'h0C1, 8, 1, 3'd0, 0, 0, 2); frame_ok("R4 msb8", 9'h0C1, 8, 0, 0);
        setup(1, 2'd1, 0, 1, 3'd0); send(9'h00B, 6, 1, 3'd0, 0, 0, 2); frame_ok("R4 msb6", 9'h00B, 6, 0, 0);
    endtask

    task automatic t_parity;
        setup(0, 2'd3, 0, 0, 3'd1); send(9'h0B7, 8, 0, 3'd1, 0, 0, 2); frame_ok("R5 even ok", 9'h0B7, 8, 0, 0);
        setup(1, 2'd3, 0, 0, 3'd1); send(9'h0B7, 8, 0, 3'd1, 1, 0, 2); frame_ok("R5 even bad", 9'h0B7, 8, 1, 0);
        setup(1, 2'd2, 0, 0, 3'd2); send(9'h011, 7, 0, 3'd2, 0, 0, 2); frame_ok("R5 odd ok", 9'h011, 7, 0, 0);
        setup(0, 2'd2, 0, 0, 3'd2); send(9'h011, 7, 0, 3'd2, 1, 0, 2); frame_ok("R5 odd bad", 9'h011, 7, 1, 0);
        setup(1, 2'd3, 0, 0, 3'd3); send(9'h0F0, 8, 0, 3'd3, 1, 0, 2); frame_ok("R5 zero bad", 9'h0F0, 8, 1, 0);
        setup(1, 2'd3, 0, 0, 3'd4); send(9'h0F0, 8, 0, 3'd4, 0, 0, 2); frame_ok("R5 one ok", 9'h0F0, 8, 0, 0);
        setup(0, 2'd3, 1, 1, 3'd1); send(9'h155, 9, 1, 3'd1, 1, 0, 2); frame_ok("R5 nine msb bad", 9'h155, 9, 1, 0);
    endtask

    task automatic t_stop;
        setup(0, 2'd3, 0, 0, 3'd0); send(9'h081, 8, 0, 3'd0, 0, 1, 2); frame_ok("R6 bad stop", 9'h081, 8, 0, 1);
        setup(1, 2'd3, 0, 0, 3'd0);
        send(9'h04E, 8, 0, 3'd0, 0, 0, 0);
        send(9'h0D2, 8, 0, 3'd0, 0, 0, 2);
        chk(n_valid == 2, "R6 back-to-back count", 9'(n_valid), 9'd2);
        chk(cap_d[0] == 9'h04E, "R6 back-to-back first", cap_d[0], 9'h04E);
        chk(cap_d[1] == 9'h0D2, "R6 back-to-back second", cap_d[1], 9'h0D2);
    endtask

    task automatic t_glitch;
        setup(0, 2'd3, 0, 0, 3'd0);
        line_ticks(1'b0, 6); line_ticks(1'b1, 40);
        chk(n_valid == 0, "R2 glitch 16x", 9'(n_valid), 9'd0);
        send(9'h066, 8, 0, 3'd0, 0, 0, 2); frame_ok("R2 after glitch 16x", 9'h066, 8, 0, 0);
        setup(1, 2'd3, 0, 0, 3'd0);
        line_ticks(1'b0, 2); line_ticks(1'b1, 20);
        chk(n_valid == 0, "R2 glitch 8x", 9'(n_valid), 9'd0);
        send(9'h099, 8, 0, 3'd0, 0, 0, 2); frame_ok("R2 after glitch 8x", 9'h099, 8, 0, 0);
    endtask

    task automatic t_both;
        setup(0, 2'd3, 0, 0, 3'd2); send(9'h03A, 8, 0, 3'd2, 1, 1, 2);
        frame_ok("R7 both errors", 9'h03A, 8, 1, 1);
        chk(cap_p[0] == 1 && cap_f[0] == 1, "R7 flags on strobe", {7'd0, cap_p[0], cap_f[0]}, 9'd3);
        line_ticks(1'b1, 64);
        chk(data_o == 9'h03A && perr_o && ferr_o, "R7 hold", data_o, 9'h03A);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        t_reset();
        t_ratio();
        t_length();
        t_order();
        t_parity();
        t_stop();
        t_glitch();
        t_both();
        report();
        $finish;
    end
endmodule